// File: doc/BRIEF.md
# Byte Programming Sequencer

This controller sits on the host side of a reprogrammable non-volatile byte memory. It drives that memory's command bus to write a stream of bytes into it. Bytes arrive on a valid/ready input, each with a target address and a last-of-session marker. Addresses may come in any order. Before the first command of a session the block raises a programming-voltage enable and holds it for the whole session.

Each byte is written by a closed pulse-and-verify loop. One attempt is a set-up command (40H), then a write of the address and data, then a wait of `PULSE_CYC` clock cycles for the program pulse. The block then writes a verify command (C0H), waits `VERIFY_CYC` cycles and reads the byte back. If the read-back data equals the wanted data, the byte is done. Otherwise the attempt is repeated, up to `MAX_PULSES` attempts for that byte. The session ends after the last byte verifies, or as soon as a byte runs out of attempts. In both cases the block writes the read command (00H), drops the voltage enable and reports the outcome.

States and transitions: `ST_IDLE` goes to `ST_RAISE` when a byte is accepted. Then `ST_RAISE` → `ST_SETUP` → `ST_LOAD` → `ST_PULSE`. `ST_PULSE` goes to `ST_VCMD` when the timer expires. `ST_VCMD` → `ST_SETTLE`, and `ST_SETTLE` goes to `ST_READ` when the timer expires. `ST_READ` → `ST_CHECK`. From `ST_CHECK` a match goes to `ST_WAIT`, or to `ST_CLOSE` if the byte was the last one. A mismatch goes back to `ST_SETUP`, or to `ST_CLOSE` with the fail flag set if the attempt limit is reached. `ST_WAIT` goes to `ST_SETUP` when the next byte is accepted. `ST_CLOSE` → `ST_DROP` → `ST_IDLE`.

Top module: `byte_pgm_sequencer`

## Requirements
- R1: After reset, `vpp_on`, `mem_we`, `mem_re`, `byte_ok`, `sess_done` and `sess_fail` are low and `in_ready` is high.
- R2: Every programming attempt is a write of 40H followed in the very next cycle by a write of the byte's address and data.
- R3: After the address/data write the bus stays idle for exactly `PULSE_CYC` cycles. The next cycle then carries a write of C0H at the byte's address.
- R4: After the C0H write the bus stays idle for exactly `VERIFY_CYC` cycles. The next cycle then carries a read strobe at the byte's address.
- R5: When the read-back data equals the byte, `byte_ok` pulses for one cycle. For a byte without the last marker, the block then returns `in_ready` high with `vpp_on` still high.
- R6: When the read-back data differs, the attempt is repeated. A byte gets at most `MAX_PULSES` address/data writes, and this count restarts at zero for each new byte.
- R7: When a byte fails verification on its `MAX_PULSES`-th attempt, the session ends: `sess_done` and `sess_fail` pulse together, and the rest of the session is not programmed. `sess_fail` is never high without `sess_done`.
- R8: At the end of every session, passed or failed, the block writes 00H. In the next cycle `vpp_on` is low and `sess_done` pulses.
- R9: `vpp_on` rises at least one cycle before the first command write of a session. No command write happens while it is low.
- R10: A byte of value FFH goes through the full attempt sequence like any other byte. It verifies on its first attempt.
- R11: Bytes are programmed correctly when presented in non-sequential address order.
- R12: `in_ready` is low while a byte is in progress. An input presented during that time is not taken, and its address is not written. While `in_ready` is high the command bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Sequencer can take a byte |
| in_addr | input | ADDR_W | Target address of the input byte |
| in_data | input | 8 | Value to program |
| in_last | input | 1 | Marks the final byte of the session |
| mem_we | output | 1 | Command-bus write strobe, one cycle per write |
| mem_re | output | 1 | Command-bus read strobe |
| mem_addr | output | ADDR_W | Command-bus address |
| mem_wdata | output | 8 | Command-bus write data (command code or program data) |
| mem_rdata | input | 8 | Read data from the memory, valid in the read-strobe cycle |
| vpp_on | output | 1 | Programming-voltage enable |
| byte_ok | output | 1 | One-cycle pulse: current byte verified |
| sess_done | output | 1 | One-cycle pulse: session closed |
| sess_fail | output | 1 | With `sess_done`: session ended on a byte that exceeded the attempt limit |

## Verification
The assertions assume the memory answers a read in the same cycle as the read strobe. They also assume the environment does not reset mid-session. Command codes are told apart from program data only by whether the write directly follows a 40H write, so the checker tracks that pairing instead of decoding raw values. The stimulus keeps to these limits with a behavioural memory that returns its array contents combinationally. That memory only clears bits after a per-address number of pulses. The tests include data bytes equal to 40H-free command-like values, an FFH byte, bytes that need the full attempt budget, and cells that can never reach the wanted value.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

    localparam logic [7:0] CMD_SETUP  = 8'h40;
    localparam logic [7:0] CMD_VERIFY = 8'hC0;
    localparam logic [7:0] CMD_READ   = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAISE,
        ST_SETUP,
        ST_LOAD,
        ST_PULSE,
        ST_VCMD,
        ST_SETTLE,
        ST_READ,
        ST_CHECK,
        ST_WAIT,
        ST_CLOSE,
        ST_DROP
    } seq_state_e;

endpackage

// File: rtl/pgm_interval_timer.sv
module pgm_interval_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgm_attempt_counter.sv
module pgm_attempt_counter #(
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CW'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/byte_pgm_sequencer.sv
module byte_pgm_sequencer
    import pgm_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PULSE_CYC  = 1250,
    parameter int VERIFY_CYC = 750,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              vpp_on,
    output logic              byte_ok,
    output logic              sess_done,
    output logic              sess_fail
);

    localparam int LONGEST = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
    localparam int TMR_W   = $clog2(LONGEST + 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [7:0]        rd_q;
    logic              last_q;
    logic              fail_q;
    logic              accept;
    logic              verified;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              cnt_at_limit;

    assign accept   = in_ready && in_valid;
    assign verified = (rd_q == data_q);
    assign tmr_load = (state_q == ST_LOAD) || (state_q == ST_VCMD);
    assign tmr_val  = (state_q == ST_VCMD) ? TMR_W'(VERIFY_CYC - 1) : TMR_W'(PULSE_CYC - 1);

    pgm_interval_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pgm_attempt_counter #(.LIMIT(MAX_PULSES)) u_attempts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .inc      (state_q == ST_LOAD),
        .at_limit (cnt_at_limit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured byte, read-back and outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= 8'hFF;
            rd_q   <= 8'hFF;
            last_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= in_addr;
                data_q <= in_data;
                last_q <= in_last;
            end
            if (accept && (state_q == ST_IDLE)) begin
                fail_q <= 1'b0;
            end else if ((state_q == ST_CHECK) && !verified && cnt_at_limit) begin
                fail_q <= 1'b1;
            end
            if (state_q == ST_READ) begin
                rd_q <= mem_rdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_RAISE;
            ST_RAISE:  state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_PULSE;
            ST_PULSE:  if (tmr_expired) state_d = ST_VCMD;
            ST_VCMD:   state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_expired) state_d = ST_READ;
            ST_READ:   state_d = ST_CHECK;
            ST_CHECK: begin
                if (verified) begin
                    state_d = last_q ? ST_CLOSE : ST_WAIT;
                end else if (cnt_at_limit) begin
                    state_d = ST_CLOSE;
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_WAIT:   if (in_valid) state_d = ST_SETUP;
            ST_CLOSE:  state_d = ST_DROP;
            ST_DROP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = CMD_READ;
        vpp_on    = 1'b1;
        byte_ok   = 1'b0;
        sess_done = 1'b0;
        sess_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                vpp_on   = 1'b0;
            end
            ST_SETUP: begin
                mem_we    = 1'b1;
                mem_wdata = CMD_SETUP;
            end
            ST_LOAD: begin
                mem_we    = 1'b1;
                mem_wdata = data_q;
            end
            ST_VCMD: begin
                mem_we    = 1'b1;
                mem_wdata = CMD_VERIFY;
            end
            ST_READ:  mem_re  = 1'b1;
            ST_CHECK: byte_ok = verified;
            ST_WAIT:  in_ready = 1'b1;
            ST_CLOSE: begin
                mem_we    = 1'b1;
                mem_wdata = CMD_READ;
            end
            ST_DROP: begin
                vpp_on    = 1'b0;
                sess_done = 1'b1;
                sess_fail = fail_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/byte_pgm_sequencer_chk.sv
module byte_pgm_sequencer_chk
    import pgm_seq_pkg::*;
#(
    parameter int PULSE_CYC  = 1250,
    parameter int MAX_PULSES = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       mem_we,
    input logic       mem_re,
    input logic [7:0] mem_wdata,
    input logic       vpp_on,
    input logic       sess_done,
    input logic       sess_fail
);

    logic        after_setup;
    int unsigned gap;
    int unsigned loads;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_setup <= 1'b0;
            gap         <= 0;
            loads       <= 0;
        end else begin
            after_setup <= mem_we && (mem_wdata == CMD_SETUP) && !after_setup;
            if (mem_we && after_setup) begin
                gap <= 0;
            end else if (gap != 32'hFFFF_FFFF) begin
                gap <= gap + 1;
            end
            if (in_valid && in_ready) begin
                loads <= 0;
            end else if (mem_we && after_setup) begin
                loads <= loads + 1;
            end
        end
    end

    AST_SETUP_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_wdata == CMD_SETUP) && !after_setup) |=> mem_we); // R2

    AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_wdata == CMD_VERIFY) && !after_setup) |-> (gap == PULSE_CYC)); // R3

    AST_ATTEMPT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && after_setup) |-> (loads < MAX_PULSES)); // R6

    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sess_fail |-> sess_done); // R7

    AST_CLOSE_BEFORE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpp_on) |-> (sess_done && $past(mem_we && (mem_wdata == CMD_READ)))); // R8

    AST_WRITE_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> vpp_on); // R9

    AST_VPP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_on) |-> !mem_we); // R9

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!mem_we && !mem_re)); // R12

endmodule

bind byte_pgm_sequencer byte_pgm_sequencer_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .vpp_on    (vpp_on),
    .sess_done (sess_done),
    .sess_fail (sess_fail)
);

// File: tb/test_byte_pgm_sequencer.sv
module test_byte_pgm_sequencer;

    localparam int AW   = 8;
    localparam int PC   = 20;
    localparam int VC   = 12;
    localparam int MAXP = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic [7:0]    in_data = 8'h00;
    logic          in_last = 1'b0;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          vpp_on, byte_ok, sess_done, sess_fail;

    always #4 clk = ~clk;

    byte_pgm_sequencer #(
        .ADDR_W(AW), .PULSE_CYC(PC), .VERIFY_CYC(VC), .MAX_PULSES(MAXP)
    ) i_byte_pgm_sequencer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .vpp_on(vpp_on),
        .byte_ok(byte_ok), .sess_done(sess_done), .sess_fail(sess_fail)
    );

    // behavioural memory: a cell clears bits only after need[] pulses
    logic [7:0] mem  [256];
    int         need [256];
    int         pcnt [256];
    int         mst = 0, cyc = 0, t_setup = 0, t_load = 0, t_c0 = 0;
    int         proto_err = 0, gap3_err = 0, gap4_err = 0, vpp_err = 0;
    logic [7:0] last_cmd = 8'hFF;
    logic [AW-1:0] vaddr = '0;
    int         ok_cnt = 0, done_cnt = 0, fail_cnt = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'hFF; need[i] = 1; pcnt[i] = 0;
        end
    end

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            if (!vpp_on) vpp_err++;
            if (mst == 1) begin
                if (cyc != t_setup + 1) proto_err++;
                pcnt[mem_addr] = pcnt[mem_addr] + 1;
                if (pcnt[mem_addr] >= need[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_wdata;
                t_load = cyc;
                mst = 0;
            end else begin
                last_cmd = mem_wdata;
                case (mem_wdata)
                    8'h40: begin mst = 1; t_setup = cyc; end
                    8'hC0: begin
                        if (cyc - t_load != PC + 1) gap3_err++;
                        t_c0 = cyc; vaddr = mem_addr;
                    end
                    8'h00: ;
                    default: proto_err++;
                endcase
            end
        end
        if (mem_re) begin
            if (cyc - t_c0 != VC + 1) gap4_err++;
            if (mem_addr != vaddr) gap4_err++;
        end
        if (byte_ok) ok_cnt++;
        if (sess_done) done_cnt++;
        if (sess_fail) fail_cnt++;
        cyc++;
    end

    int total = 0, fails = 0;

    task automatic check(input logic cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] d, input logic l);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d; in_last = l;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_outcome(input int ok0, input int done0);
        int n = 0;
        while (ok_cnt == ok0 && done_cnt == done0 && n < 20000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic wait_done(input int done0);
        int n = 0;
        while (done_cnt == done0 && n < 20000) begin
            @(negedge clk); n++;
        end
    endtask

    // addr, data, pulses needed, last
    localparam logic [24:0] VEC [5] = '{
        {8'h12, 8'hA5, 8'd1,  1'b0},
        {8'h03, 8'h3C, 8'd3,  1'b0},
        {8'h7F, 8'h00, 8'd25, 1'b0},
        {8'h44, 8'hFF, 8'd1,  1'b0},
        {8'h05, 8'h81, 8'd2,  1'b1}
    };

    initial begin : main
        int ok0, done0, fail0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(vpp_on == 1'b0, "R1 vpp", vpp_on, 0);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        check(!mem_we && !mem_re, "R1 bus", {mem_we, mem_re}, 0);
        check(!byte_ok && !sess_done && !sess_fail, "R1 status", {byte_ok, sess_done, sess_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // session 1: table walk, random order
        for (int i = 0; i < 5; i++) need[VEC[i][24:17]] = int'(VEC[i][8:1]);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] a, d;
            a = VEC[i][24:17]; d = VEC[i][16:9];
            ok0 = ok_cnt; done0 = done_cnt; fail0 = fail_cnt;
            push(a, d, VEC[i][0]);
            if (i == 0) begin
                // R9: voltage up, no command yet
                check(vpp_on == 1'b1 && !mem_we, "R9 vpp leads", {vpp_on, mem_we}, 2);
            end
            if (i == 1) begin
                // R12: input offered while busy is not taken
                for (int k = 0; k < 5; k++) begin
                    in_valid = 1'b1; in_addr = 8'hEE; in_data = 8'h00; in_last = 1'b0;
                    check(in_ready == 1'b0, "R12 busy", in_ready, 0);
                    @(negedge clk);
                end
                in_valid = 1'b0;
            end
            if (VEC[i][0]) begin
                wait_done(done0);
                check(ok_cnt == ok0 + 1, "R5 last ok", ok_cnt - ok0, 1);
                check(fail_cnt == fail0, "R8 pass no fail", fail_cnt - fail0, 0);
                check(vpp_on == 1'b0, "R8 vpp dropped", vpp_on, 0);
                check(last_cmd == 8'h00, "R8 read cmd", last_cmd, 8'h00);
            end else begin
                wait_outcome(ok0, done0);
                check(ok_cnt == ok0 + 1, "R5 byte ok", ok_cnt - ok0, 1);
                check(vpp_on && in_ready, "R5 vpp held", {vpp_on, in_ready}, 3);
            end
            check(pcnt[a] == int'(VEC[i][8:1]), (d == 8'hFF) ? "R10 pulses" : "R6 pulses", pcnt[a], int'(VEC[i][8:1]));
            check(mem[a] == d, "R11 stored", mem[a], d);
        end
        check(mem[8'hEE] == 8'hFF && pcnt[8'hEE] == 0, "R12 untouched", mem[8'hEE], 8'hFF);
        check(proto_err == 0, "R2 pairing", proto_err, 0);
        check(gap3_err == 0, "R3 pulse wait", gap3_err, 0);
        check(gap4_err == 0, "R4 verify wait", gap4_err, 0);
        check(vpp_err == 0, "R9 write w/o vpp", vpp_err, 0);

        // session 2: a cell that cannot reach the value
        mem[8'h31] = 8'h00;
        done0 = done_cnt; fail0 = fail_cnt; ok0 = ok_cnt;
        push(8'h30, 8'h66, 1'b0);
        wait_outcome(ok0, done0);
        check(ok_cnt == ok0 + 1, "R5 pre-fail byte", ok_cnt - ok0, 1);
        push(8'h31, 8'h5A, 1'b0);
        wait_done(done0);
        check(fail_cnt == fail0 + 1, "R7 fail flagged", fail_cnt - fail0, 1);
        check(pcnt[8'h31] == MAXP, "R6 limit", pcnt[8'h31], MAXP);
        check(vpp_on == 1'b0 && in_ready == 1'b1, "R8 close after fail", {vpp_on, in_ready}, 1);
        check(last_cmd == 8'h00, "R8 read cmd fail", last_cmd, 8'h00);
        repeat (50) @(negedge clk);
        check(!mem_we && done_cnt == done0 + 1, "R7 stays closed", done_cnt - done0, 1);

        // session 3: slow cell needing one more than the limit
        need[8'h40] = MAXP + 1;
        done0 = done_cnt; fail0 = fail_cnt;
        push(8'h40, 8'h11, 1'b1);
        wait_done(done0);
        check(fail_cnt == fail0 + 1, "R7 slow cell", fail_cnt - fail0, 1);
        check(pcnt[8'h40] == MAXP, "R6 fresh count", pcnt[8'h40], MAXP);
        check(mem[8'h40] == 8'hFF, "R7 unprogrammed", mem[8'h40], 8'hFF);
        check(proto_err == 0 && gap3_err == 0 && gap4_err == 0, "R2 R3 R4 end", proto_err + gap3_err + gap4_err, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 8);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule